// File: doc/BRIEF.md
# Sticky Reset-Cause Status Register

This block records why the chip was last reset. It has four cause flags: software reset, independent-watchdog reset, window-watchdog reset and low-power reset. The reset controller sends a one-cycle pulse for a cause, and the matching flag sets and stays set. The flags build up over several resets. They are not affected by a system reset. Only a power-on reset, or a software write to a self-clearing clear bit, returns them to zero.

The same 32-bit word also holds a small writable control byte. This byte behaves like ordinary system state: a system reset clears it. The bus port writes byte lanes under per-lane enables, so byte, halfword and word accesses are all legal. Reads return the whole word combinationally.

Top module: `rst_cause_reg`

## Requirements
- R1: While porRstN is low, and after it rises, busRdata reads 0x0000_0000 and ctrlOut reads 0x00.
- R2: A high causePulse[i] at a rising clock edge sets the flag at busRdata bit 28+i. Index 0 is software, 1 is independent watchdog, 2 is window watchdog and 3 is low-power.
- R3: Flags accumulate. A new pulse never clears a flag that is already set.
- R4: Holding sysRstN low leaves every flag unchanged.
- R5: While sysRstN is low, the control byte (busRdata[7:0] and ctrlOut) reads 0x00.
- R6: A write with busSel, busWrite, busByteEn[3] and busWdata[24] all high clears every flag at that edge.
- R7: busRdata bit 24, the clear bit, always reads 0.
- R8: When a clear write and a cause pulse fall in the same cycle, the pulsed flags end set and all other flags end cleared.
- R9: Writing ones to busRdata bits 31:28 through the bus has no effect on the flags.
- R10: A write with busByteEn[0] high loads busWdata[7:0] into the control byte, which ctrlOut mirrors. Without busSel and busWrite both high, the control byte keeps its value.
- R11: A clear write with busByteEn[3] low leaves the flags unchanged.
- R12: A power-on reset clears flags that are already set, as well as the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, asynchronous, active low; clears everything |
| sysRstN | input | 1 | System reset, asynchronous, active low; clears the control byte only |
| busSel | input | 1 | Register select |
| busWrite | input | 1 | Write strobe, qualified by busSel |
| busByteEn | input | 4 | Byte-lane enables |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data: flags at 31:28, clear bit 24 (reads 0), control byte at 7:0 |
| causePulse | input | 4 | One-cycle reset-cause pulses from the reset controller |
| ctrlOut | output | 8 | Current control byte |

## Verification
Two functions can act on the flags in the same cycle: the software clear and a hardware set. The bench drives a clear write through lane 3 together with a pulse on a single cause. The pulsed flag must survive while every other flag that was set goes to zero. A second pairing places a system reset over flags that are already set. The expected word is checked on the falling edge that follows.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int DATA_W   = 32;
  localparam int FLAG_W   = 4;
  localparam int CTRL_W   = 8;
  localparam int FLAG_LSB = 28;
  localparam int CLR_BIT  = 24;
  localparam int LANES    = DATA_W / 8;
  localparam int CLR_LANE = CLR_BIT / 8;

  typedef struct packed {
    logic              clearFlags;
    logic [CTRL_W-1:0] ctrlWe;
    logic [CTRL_W-1:0] ctrlWdata;
  } strobe_t;
endpackage

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [LANES-1:0]  busByteEn,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           strobe
);
  logic wrAct;
  assign wrAct = busSel & busWrite;

  assign strobe.clearFlags = wrAct & busByteEn[CLR_LANE] & busWdata[CLR_BIT];

  for (genvar b = 0; b < CTRL_W; b++) begin : g_ctrlBit
    assign strobe.ctrlWe[b]    = wrAct & busByteEn[b/8];
    assign strobe.ctrlWdata[b] = busWdata[b];
  end
endmodule

// File: rtl/rst_cause_dp.sv
module rst_cause_dp
  import rst_cause_pkg::*;
(
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  strobe_t           strobe,
  input  logic [FLAG_W-1:0] causePulse,
  output logic [DATA_W-1:0] busRdata,
  output logic [CTRL_W-1:0] ctrlOut
);
  logic [FLAG_W-1:0] flagQ;
  logic [CTRL_W-1:0] ctrlQ;
  logic              ctrlRstN;

  assign ctrlRstN = porRstN & sysRstN;

  // flags: only the power-on reset reaches them; set wins over clear
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) flagQ <= '0;
    else          flagQ <= (flagQ & ~{FLAG_W{strobe.clearFlags}}) | causePulse;
  end

  // control byte follows system reset as well
  always_ff @(posedge clk or negedge ctrlRstN) begin
    if (!ctrlRstN) ctrlQ <= '0;
    else           ctrlQ <= (ctrlQ & ~strobe.ctrlWe) | (strobe.ctrlWdata & strobe.ctrlWe);
  end

  always_comb begin
    busRdata = '0;
    busRdata[FLAG_LSB +: FLAG_W] = flagQ;
    busRdata[0 +: CTRL_W]        = ctrlQ;
  end

  assign ctrlOut = ctrlQ;
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
(
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [LANES-1:0]  busByteEn,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [FLAG_W-1:0] causePulse,
  output logic [CTRL_W-1:0] ctrlOut
);
  strobe_t strobe;

  rst_cause_ctrl u_ctrl (
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busByteEn (busByteEn),
    .busWdata  (busWdata),
    .strobe    (strobe)
  );

  rst_cause_dp u_dp (
    .clk        (clk),
    .porRstN    (porRstN),
    .sysRstN    (sysRstN),
    .strobe     (strobe),
    .causePulse (causePulse),
    .busRdata   (busRdata),
    .ctrlOut    (ctrlOut)
  );
endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk
  import rst_cause_pkg::*;
(
  input logic              clk,
  input logic              porRstN,
  input logic              sysRstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [LANES-1:0]  busByteEn,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [FLAG_W-1:0] causePulse,
  input logic [CTRL_W-1:0] ctrlOut
);
  logic [FLAG_W-1:0] flagsSeen;
  logic              clrSeen;
  assign flagsSeen = busRdata[FLAG_LSB +: FLAG_W];
  assign clrSeen   = busSel & busWrite & busByteEn[CLR_LANE] & busWdata[CLR_BIT];

  // R2
  pulse_sets_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (causePulse != '0) |=> ((flagsSeen & $past(causePulse)) == $past(causePulse)));

  // R3
  no_drop_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !clrSeen |=> ((flagsSeen & $past(flagsSeen)) == $past(flagsSeen)));

  // R9
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (causePulse == '0) |=> ((flagsSeen & ~$past(flagsSeen)) == '0));

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (clrSeen && causePulse == '0) |=> (flagsSeen == '0));

  // R7
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!porRstN)
    busRdata[CLR_BIT] == 1'b0);

  // R5
  sys_clears_ctrl_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !sysRstN |-> (ctrlOut == '0));
endmodule

bind rst_cause_reg rst_cause_chk u_chk (.*);

// File: tb/rst_cause_reg_bench.sv
module rst_cause_reg_bench;
  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        sysRstN = 1'b1;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  causePulse = '0;
  logic [7:0]  ctrlOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  rst_cause_reg u_rst_cause_reg (.*);

  typedef struct packed {
    logic        sel;
    logic        wr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [3:0]  pulse;
    logic        sys;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,4'h0,32'h0000_0000,4'h0,1'b0,32'h0000_0000,8'd1},  // R1 idle
    '{1'b0,1'b0,4'h0,32'h0000_0000,4'h1,1'b0,32'h1000_0000,8'd2},  // R2 software
    '{1'b0,1'b0,4'h0,32'h0000_0000,4'h4,1'b0,32'h5000_0000,8'd3},  // R3 accumulate
    '{1'b1,1'b1,4'h1,32'h0000_00A5,4'h0,1'b0,32'h5000_00A5,8'd10}, // R10 byte write
    '{1'b0,1'b0,4'h0,32'h0000_0000,4'h0,1'b1,32'h5000_0000,8'd4},  // R4 R5 system reset
    '{1'b1,1'b1,4'hF,32'hF000_0033,4'h0,1'b0,32'h5000_0033,8'd9},  // R9 flag bits ignored
    '{1'b1,1'b1,4'h7,32'h0100_0000,4'h0,1'b0,32'h5000_0000,8'd11}, // R11 lane3 off
    '{1'b1,1'b1,4'h8,32'h0100_0000,4'h0,1'b0,32'h0000_0000,8'd6},  // R6 R7 clear
    '{1'b0,1'b0,4'h0,32'h0000_0000,4'hA,1'b0,32'hA000_0000,8'd3},  // R3 two at once
    '{1'b1,1'b1,4'hC,32'h0100_0000,4'h2,1'b0,32'h2000_0000,8'd8},  // R8 set beats clear
    '{1'b0,1'b1,4'h1,32'h0000_007E,4'h0,1'b0,32'h2000_0000,8'd10}, // R10 no select
    '{1'b0,1'b0,4'h0,32'h0000_0000,4'hF,1'b0,32'hF000_0000,8'd2}   // R2 all causes
  };

  task automatic check(input logic [31:0] exp, input string tag);
    nChecks++;
    if (busRdata !== exp || ctrlOut !== exp[7:0]) begin
      nFails++;
      $display("FAIL %s: rdata=%h ctrl=%h expected rdata=%h ctrl=%h",
               tag, busRdata, ctrlOut, exp, exp[7:0]);
    end
  endtask

  task automatic step(input logic sel, input logic wr, input logic [3:0] be,
                      input logic [31:0] wd, input logic [3:0] pulse, input logic sys);
    busSel = sel; busWrite = wr; busByteEn = be; busWdata = wd;
    causePulse = pulse; sysRstN = ~sys;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busByteEn = '0; busWdata = '0; causePulse = '0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(32'h0, "R1 in reset");
    porRstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].sel, VECS[i].wr, VECS[i].be, VECS[i].wd, VECS[i].pulse, VECS[i].sys);
      check(VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
      sysRstN = 1'b1;
    end
    // R12: power-on reset wipes set flags and control byte
    step(1'b1, 1'b1, 4'h1, 32'h0000_005A, 4'h0, 1'b0);
    check(32'hF000_005A, "R10 before power-on reset");
    porRstN = 1'b0;
    #1;
    check(32'h0, "R12 power-on reset");
    @(negedge clk);
    porRstN = 1'b1;
    @(negedge clk);
    check(32'h0, "R1 after power-on reset");
    // R7 R9 R6: word of all ones clears flags, clear bit reads 0
    step(1'b0, 1'b0, 4'h0, 32'h0, 4'h5, 1'b0);
    step(1'b1, 1'b1, 4'hF, 32'hFFFF_FFFF, 4'h0, 1'b0);
    check(32'h0000_00FF, "R7 all-ones word write");
    // R4: system reset with a pulse inside keeps old and new flags
    step(1'b0, 1'b0, 4'h0, 32'h0, 4'h8, 1'b0);
    step(1'b0, 1'b0, 4'h0, 32'h0, 4'h1, 1'b1);
    check(32'h9000_0000, "R4 pulse during system reset");
    sysRstN = 1'b1;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 2000 && !done; c++) @(negedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule